// File: doc/BRIEF.md
# Register-Mapped Serial Channel Controller

This block is the register front end of one serial channel. A processor reaches it through a simple bus: one access per cycle, with a select, a write strobe, a six-bit byte address and 8-bit data. The processor loads two mode registers, issues commands, watches a status byte and an interrupt status byte, and moves data. Received bytes come from a byte-level receiver on an input strobe and wait in a four-entry FIFO. Line-break events also arrive on that interface. Transmit bytes sit in a one-byte holding register and leave on a valid/ready byte stream.

Bit serialization, baud generation and line error detection happen outside this block. The baud divisor is a fixed parameter that can be read back. A single level interrupt combines the transmit-ready, receive and break conditions through a software mask.

Top module: `uart_chan_ctrl`

## Requirements
- R1: After reset the FIFO is empty, both mode registers, the interrupt status and the mask are zero, and both directions are disabled. The status byte (read at 0x04) is 0x08, the interrupt status (read at 0x14) is 0x00, and `irq` and `tx_valid` are low.
- R2: Bus address 0x00 reaches mode register 0 or 1 through a pointer that starts at 0. Every write there moves the pointer to 1. Misc command code 1 moves it back to 0. A read returns the register the pointer selects.
- R3: A write to the command register (0x08) decodes three fields. Bits 1:0 drive the receiver (1 enables, 2 disables). Bits 3:2 drive the transmitter the same way. Bits 6:4 hold a misc code. The value 3 in either enable field changes nothing. Status bit 2 (transmitter ready) equals the transmitter enable.
- R4: Misc code 2 disables the receiver and empties the FIFO. Misc code 3 disables the transmitter and discards a held byte, so status bit 3 (holding register empty) sets. Misc codes 4, 6 and 7 change no state. The misc action comes before the enable fields of the same write.
- R5: A read of 0x0C returns the oldest FIFO byte and removes it, or returns 0 when the FIFO is empty. Status bit 0 is set while the FIFO is non-empty. Status bit 1 is set while it holds four bytes.
- R6: A byte on `rx_valid` is stored only while the receiver is enabled and the FIFO is not full. `rx_ready` shows exactly this condition.
- R7: A pulse on `rx_break` sets interrupt status bit 2 and stores a zero byte, whether or not the receiver is enabled. When the FIFO is full, the zero byte replaces the newest entry. Misc code 5 clears bit 2.
- R8: A write to 0x0C loads the holding register and clears status bit 3. While the transmitter is enabled, the byte is offered on `tx_valid`/`tx_data`, and bit 3 sets again at the cycle where `tx_ready` is high. While the transmitter is disabled, the byte stays held.
- R9: Interrupt status bit 0 follows transmitter ready. Bit 1 follows status bit 1 when bit 6 of mode register 0 is set, and follows status bit 0 otherwise. Bits 7 and 6:3 read as zero.
- R10: A write to 0x14 loads the mask. `irq` is high exactly when the interrupt status and the mask share a set bit.
- R11: Writes to 0x04 and 0x10 change nothing. A read of 0x10 returns 0. Reads of 0x18 and 0x1C return the high and low bytes of the BAUD_DIV parameter.
- R12: Every bus write, push or pop updates state at the clock edge that ends its cycle. Status, interrupt status, `rx_ready`, `irq` and read data reflect that update in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the access cycle |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_break | input | 1 | Line-break event strobe |
| rx_ready | output | 1 | A received byte would be stored |
| tx_valid | output | 1 | Transmit byte offered |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Sink takes the transmit byte |
| irq | output | 1 | Level interrupt request |

## Verification
Read data is combinational, so the bench samples it inside the access cycle, before the edge that performs a pop. Every other result is due one edge after its stimulus. Status, interrupt status, `rx_ready` and `irq` are compared at the falling edge that follows the committing rising edge.

A held transmit byte is offered in the cycle after its enable or load, and it leaves at the next edge when `tx_ready` is high. The bench therefore checks `tx_valid`/`tx_data` in that cycle and expects the holding register to be empty only after one more edge. Reference values come from a behavioural model in the bench, updated once per bus or receive operation.

// File: rtl/uart_chan_pkg.sv
package uart_chan_pkg;

  // Register slots, selected by bus address bits 5:2.
  typedef enum logic [3:0] {
    SLOT_MODE = 4'h0,
    SLOT_STAT = 4'h1,
    SLOT_CMD  = 4'h2,
    SLOT_DATA = 4'h3,
    SLOT_AUX  = 4'h4,
    SLOT_IRQ  = 4'h5,
    SLOT_BRH  = 4'h6,
    SLOT_BRL  = 4'h7
  } reg_slot_e;

  typedef enum logic [2:0] {
    MISC_NOP      = 3'd0,
    MISC_PTR_RST  = 3'd1,
    MISC_RX_RST   = 3'd2,
    MISC_TX_RST   = 3'd3,
    MISC_ERR_RST  = 3'd4,
    MISC_BRK_CLR  = 3'd5,
    MISC_BRK_ON   = 3'd6,
    MISC_BRK_OFF  = 3'd7
  } misc_code_e;

  typedef struct packed {
    logic       spare;
    misc_code_e misc;
    logic [1:0] tx_fld;
    logic [1:0] rx_fld;
  } cmd_word_t;

  // Mode register 0 bit that moves the receive interrupt to "FIFO full".
  localparam int MODE_RXSEL_BIT = 6;

  function automatic cmd_word_t split_cmd(input logic [7:0] b);
    return cmd_word_t'(b);
  endfunction

  // Enable-field rule: 1 sets, 2 clears, 0 and 3 keep.
  function automatic logic field_next(input logic cur, input logic [1:0] fld);
    case (fld)
      2'd1:    return 1'b1;
      2'd2:    return 1'b0;
      default: return cur;
    endcase
  endfunction

  function automatic logic [7:0] pack_status(input logic txemp, input logic txrdy,
                                             input logic ffull, input logic rxrdy);
    return {4'b0000, txemp, txrdy, ffull, rxrdy};
  endfunction

  function automatic logic rx_int_pick(input logic sel_full, input logic ffull,
                                       input logic rxrdy);
    return sel_full ? ffull : rxrdy;
  endfunction

  function automatic logic [7:0] pack_isr(input logic brk, input logic rxint,
                                          input logic txint);
    return {5'b00000, brk, rxint, txint};
  endfunction

endpackage

// File: rtl/uart_rxq.sv
module uart_rxq #(
  parameter int DEPTH = 4,
  parameter int W     = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          pop,
  input  logic          push,
  input  logic          force_push,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_ptr;
  logic [CW-1:0] count_n;
  logic [PW-1:0] wr_slot, newest_slot;
  logic          can_pop, room, wr_norm, wr_over;

  function automatic logic [PW-1:0] wrap_idx(input int unsigned s);
    return PW'(s % DEPTH);
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign dout    = mem[rd_ptr];
  assign can_pop = pop && !empty;
  assign room    = !full || can_pop;
  assign wr_norm = push && room;
  assign wr_over = push && force_push && !room;

  always_comb begin
    wr_slot     = wrap_idx(int'(rd_ptr) + int'(count));
    newest_slot = wrap_idx(int'(rd_ptr) + int'(count) + DEPTH - 1);
    count_n     = count;
    if (can_pop) count_n = count_n - 1'b1;
    if (wr_norm) count_n = count_n + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      count <= count_n;
      if (can_pop) rd_ptr <= wrap_idx(int'(rd_ptr) + 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && !flush) begin
      if (wr_norm)      mem[wr_slot]     <= din;
      else if (wr_over) mem[newest_slot] <= din;
    end
  end

endmodule

// File: rtl/uart_cmd_exec.sv
module uart_cmd_exec
  import uart_chan_pkg::*;
(
  input  logic       cmd_we,
  input  logic [7:0] cmd_byte,
  input  logic       tx_en,
  input  logic       rx_en,
  output logic       tx_en_n,
  output logic       rx_en_n,
  output logic       ptr_rst,
  output logic       rx_flush,
  output logic       tx_discard,
  output logic       brk_clr
);

  cmd_word_t c;
  logic      tx_mid, rx_mid;

  always_comb begin
    c          = split_cmd(cmd_byte);
    ptr_rst    = cmd_we && (c.misc == MISC_PTR_RST);
    rx_flush   = cmd_we && (c.misc == MISC_RX_RST);
    tx_discard = cmd_we && (c.misc == MISC_TX_RST);
    brk_clr    = cmd_we && (c.misc == MISC_BRK_CLR);
    tx_mid     = tx_discard ? 1'b0 : tx_en;
    rx_mid     = rx_flush   ? 1'b0 : rx_en;
    tx_en_n    = cmd_we ? field_next(tx_mid, c.tx_fld) : tx_en;
    rx_en_n    = cmd_we ? field_next(rx_mid, c.rx_fld) : rx_en;
  end

endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         discard,
  input  logic         tx_en,
  input  logic         tx_ready,
  output logic         tx_valid,
  output logic [W-1:0] tx_data,
  output logic         hold_empty,
  output logic         tx_fire
);

  logic [W-1:0] hold_q;
  logic         empty_q;

  assign tx_valid   = tx_en && !empty_q;
  assign tx_data    = hold_q;
  assign hold_empty = empty_q;
  assign tx_fire    = tx_valid && tx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      empty_q <= 1'b1;
      hold_q  <= '0;
    end else if (discard) begin
      empty_q <= 1'b1;
    end else if (load) begin
      empty_q <= 1'b0;
      hold_q  <= din;
    end else if (tx_fire) begin
      empty_q <= 1'b1;
    end
  end

endmodule

// File: rtl/uart_irq_gen.sv
module uart_irq_gen
  import uart_chan_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       brk_set,
  input  logic       brk_clr,
  input  logic       mask_we,
  input  logic [7:0] mask_wdata,
  input  logic       tx_rdy,
  input  logic       rx_rdy,
  input  logic       ffull,
  input  logic       sel_full,
  output logic [7:0] isr,
  output logic [7:0] mask,
  output logic       irq
);

  logic brk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      brk_q <= 1'b0;
      mask  <= '0;
    end else begin
      if (brk_set)      brk_q <= 1'b1;
      else if (brk_clr) brk_q <= 1'b0;
      if (mask_we) mask <= mask_wdata;
    end
  end

  assign isr = pack_isr(brk_q, rx_int_pick(sel_full, ffull, rx_rdy), tx_rdy);
  assign irq = |(isr & mask);

endmodule

// File: rtl/uart_chan_ctrl.sv
module uart_chan_ctrl
  import uart_chan_pkg::*;
#(
  parameter int          DEPTH    = 4,
  parameter logic [15:0] BAUD_DIV = 16'h012C,
  localparam int         CW       = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic [5:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       rx_break,
  output logic       rx_ready,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  input  logic       tx_ready,
  output logic       irq
);

  reg_slot_e slot;
  logic wr_mode, wr_cmd, wr_data, wr_mask, rd_data;
  logic [7:0] mode_q [2];
  logic       mptr_q, tx_en_q, rx_en_q;
  logic       tx_en_n, rx_en_n, ptr_rst, flush_evt, tx_discard, brk_clr;
  logic       pop_evt, push_evt, push_acc;
  logic [7:0] q_dout, push_byte;
  logic [CW-1:0] q_count;
  logic       q_full, q_empty, hold_empty, tx_fire;
  logic [7:0] isr, mask, status;

  assign slot    = reg_slot_e'(bus_addr[5:2]);
  assign wr_mode = bus_sel && bus_wr && (slot == SLOT_MODE);
  assign wr_cmd  = bus_sel && bus_wr && (slot == SLOT_CMD);
  assign wr_data = bus_sel && bus_wr && (slot == SLOT_DATA);
  assign wr_mask = bus_sel && bus_wr && (slot == SLOT_IRQ);
  assign rd_data = bus_sel && !bus_wr && (slot == SLOT_DATA);

  assign rx_ready  = rx_en_q && !q_full;
  assign push_acc  = rx_valid && rx_ready;
  assign push_evt  = rx_break || push_acc;
  assign push_byte = rx_break ? 8'h00 : rx_data;
  assign pop_evt   = rd_data;

  uart_cmd_exec u_cmd (
    .cmd_we(wr_cmd), .cmd_byte(bus_wdata), .tx_en(tx_en_q), .rx_en(rx_en_q),
    .tx_en_n(tx_en_n), .rx_en_n(rx_en_n), .ptr_rst(ptr_rst),
    .rx_flush(flush_evt), .tx_discard(tx_discard), .brk_clr(brk_clr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q[0] <= '0;
      mode_q[1] <= '0;
      mptr_q    <= 1'b0;
      tx_en_q   <= 1'b0;
      rx_en_q   <= 1'b0;
    end else begin
      tx_en_q <= tx_en_n;
      rx_en_q <= rx_en_n;
      if (wr_mode) begin
        mode_q[mptr_q] <= bus_wdata;
        mptr_q         <= 1'b1;
      end else if (ptr_rst) begin
        mptr_q <= 1'b0;
      end
    end
  end

  uart_rxq #(.DEPTH(DEPTH), .W(8)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(flush_evt), .pop(pop_evt),
    .push(push_evt), .force_push(rx_break), .din(push_byte),
    .dout(q_dout), .count(q_count), .full(q_full), .empty(q_empty)
  );

  uart_tx_hold #(.W(8)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(wr_data), .din(bus_wdata),
    .discard(tx_discard), .tx_en(tx_en_q), .tx_ready(tx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .hold_empty(hold_empty),
    .tx_fire(tx_fire)
  );

  uart_irq_gen u_irq (
    .clk(clk), .rst_n(rst_n), .brk_set(rx_break), .brk_clr(brk_clr),
    .mask_we(wr_mask), .mask_wdata(bus_wdata), .tx_rdy(tx_en_q),
    .rx_rdy(!q_empty), .ffull(q_full), .sel_full(mode_q[0][MODE_RXSEL_BIT]),
    .isr(isr), .mask(mask), .irq(irq)
  );

  assign status = pack_status(hold_empty, tx_en_q, q_full, !q_empty);

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_sel && !bus_wr) begin
      case (slot)
        SLOT_MODE: bus_rdata = mode_q[mptr_q];
        SLOT_STAT: bus_rdata = status;
        SLOT_DATA: bus_rdata = q_empty ? 8'h00 : q_dout;
        SLOT_IRQ:  bus_rdata = isr;
        SLOT_BRH:  bus_rdata = BAUD_DIV[15:8];
        SLOT_BRL:  bus_rdata = BAUD_DIV[7:0];
        default:   bus_rdata = 8'h00;
      endcase
    end
  end

endmodule

// File: rtl/uart_chan_ctrl_chk.sv
module uart_chan_ctrl_chk #(
  parameter int  DEPTH = 4,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_wr,
  input logic [5:0]    bus_addr,
  input logic [7:0]    bus_wdata,
  input logic [7:0]    bus_rdata,
  input logic          rx_valid,
  input logic          rx_break,
  input logic          rx_ready,
  input logic          tx_valid,
  input logic          irq,
  input logic          tx_en,
  input logic [CW-1:0] q_count,
  input logic          q_empty,
  input logic          pop_evt,
  input logic          flush_evt,
  input logic [7:0]    isr,
  input logic [7:0]    mask
);

  assert_depth_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CW'(DEPTH));

  assert_empty_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr[5:2] == 4'h3 && q_empty) |-> bus_rdata == 8'h00);

  assert_push_grows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_break && rx_ready && !pop_evt && !flush_evt)
      |=> q_count == $past(q_count) + 1'b1);

  assert_blocked_push_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_break && !rx_ready && !pop_evt && !flush_evt)
      |=> q_count == $past(q_count));

  assert_break_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_break |=> isr[2]);

  assert_tx_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> tx_en);

  assert_tx_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr[5:2] == 4'h2 && bus_wdata[3:2] == 2'd1) |=> tx_en);

  assert_mask_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == 8'h00) |-> !irq);

endmodule

bind uart_chan_ctrl uart_chan_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .rx_valid(rx_valid), .rx_break(rx_break), .rx_ready(rx_ready),
  .tx_valid(tx_valid), .irq(irq), .tx_en(tx_en_q), .q_count(q_count),
  .q_empty(q_empty), .pop_evt(pop_evt), .flush_evt(flush_evt),
  .isr(isr), .mask(mask)
);

// File: tb/uart_chan_ctrl_test.sv
module uart_chan_ctrl_test;

  localparam logic [15:0] BAUD = 16'h012C;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       rx_valid = 1'b0, rx_break = 1'b0, tx_ready = 1'b1;
  logic [7:0] rx_data = '0;
  logic       rx_ready, tx_valid, irq;
  logic [7:0] tx_data;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // Reference model state
  logic [7:0] m_q [4];
  int         m_cnt;
  logic [7:0] m_mode0, m_mode1, m_mask, m_tb;
  logic       m_ptr, m_txen, m_rxen, m_txemp, m_brk;

  uart_chan_ctrl #(.DEPTH(4), .BAUD_DIV(BAUD)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_break(rx_break),
    .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_status();
    return {4'b0, m_txemp, m_txen, (m_cnt == 4), (m_cnt != 0)};
  endfunction

  function automatic logic [7:0] exp_isr();
    logic rxi;
    rxi = m_mode0[6] ? (m_cnt == 4) : (m_cnt != 0);
    return {5'b0, m_brk, rxi, m_txen};
  endfunction

  task automatic model_reset();
    m_cnt = 0; m_mode0 = 0; m_mode1 = 0; m_mask = 0; m_tb = 0;
    m_ptr = 0; m_txen = 0; m_rxen = 0; m_txemp = 1; m_brk = 0;
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [7:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [7:0] q);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #2 q = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic model_push(input logic [7:0] d, input bit brk);
    if (brk) begin
      m_brk = 1;
      if (m_cnt == 4) m_q[3] = 8'h00;
      else begin m_q[m_cnt] = 8'h00; m_cnt++; end
    end else if (m_rxen && m_cnt < 4) begin
      m_q[m_cnt] = d; m_cnt++;
    end
  endtask

  task automatic do_rx(input logic [7:0] d, input bit brk);
    chk("R6 rx_ready", {7'b0, rx_ready}, {7'b0, (m_rxen && m_cnt < 4)});
    rx_valid = !brk; rx_break = brk; rx_data = d;
    @(posedge clk); @(negedge clk);
    rx_valid = 0; rx_break = 0;
    model_push(d, brk);
  endtask

  task automatic do_pop(input string req);
    logic [7:0] q, e;
    e = (m_cnt != 0) ? m_q[0] : 8'h00;
    bus_read(6'h0C, q);
    chk(req, q, e);
    if (m_cnt != 0) begin
      for (int i = 0; i < 3; i++) m_q[i] = m_q[i+1];
      m_cnt--;
    end
  endtask

  task automatic do_cmd(input logic [7:0] c);
    bus_write(6'h08, c);
    case (c[6:4])
      3'd1: m_ptr = 0;
      3'd2: begin m_rxen = 0; m_cnt = 0; end
      3'd3: begin m_txen = 0; m_txemp = 1; end
      3'd5: m_brk = 0;
      default: ;
    endcase
    if (c[3:2] == 2'd1) m_txen = 1; else if (c[3:2] == 2'd2) m_txen = 0;
    if (c[1:0] == 2'd1) m_rxen = 1; else if (c[1:0] == 2'd2) m_rxen = 0;
  endtask

  // With tx_ready high, a held byte goes out one cycle after it became sendable.
  task automatic tx_settle();
    if (m_txen && !m_txemp) begin
      chk("R8 tx_valid", {7'b0, tx_valid}, 8'h01);
      chk("R8 tx_data", tx_data, m_tb);
      @(posedge clk); @(negedge clk);
      m_txemp = 1;
    end else begin
      chk("R8 tx idle", {7'b0, tx_valid}, 8'h00);
    end
  endtask

  task automatic chk_status(input string req);
    logic [7:0] q;
    bus_read(6'h04, q);
    chk(req, q, exp_status());
  endtask

  task automatic chk_isr_irq();
    logic [7:0] q;
    bus_read(6'h14, q);
    chk("R9 isr", q, exp_isr());
    chk("R10 irq", {7'b0, irq}, {7'b0, |(exp_isr() & m_mask)});
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] q;
    int seed;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1 reset state
    chk_status("R1 reset status");
    bus_read(6'h14, q); chk("R1 reset isr", q, 8'h00);
    chk("R1 reset irq", {7'b0, irq}, 8'h00);
    chk("R1 reset tx_valid", {7'b0, tx_valid}, 8'h00);
    bus_read(6'h00, q); chk("R1 reset mode0", q, 8'h00);
    do_pop("R5 empty read");

    // R11 auxiliary offsets
    bus_read(6'h10, q); chk("R11 offset 0x10", q, 8'h00);
    bus_read(6'h18, q); chk("R11 baud high", q, BAUD[15:8]);
    bus_read(6'h1C, q); chk("R11 baud low", q, BAUD[7:0]);
    bus_write(6'h04, 8'hFF); bus_write(6'h10, 8'hFF);
    chk_status("R11 ignored writes");

    // R2 mode pointer
    bus_write(6'h00, 8'h11); m_mode0 = 8'h11; m_ptr = 1;
    bus_read(6'h00, q); chk("R2 read mode1 after write", q, 8'h00);
    bus_write(6'h00, 8'h22); m_mode1 = 8'h22;
    bus_read(6'h00, q); chk("R2 mode1 value", q, 8'h22);
    do_cmd(8'h10);
    bus_read(6'h00, q); chk("R2 pointer reset", q, 8'h11);

    // R3 reserved fields, R4 no-effect misc codes
    do_cmd(8'h0F);
    chk_status("R3 reserved fields");
    do_cmd(8'h05); tx_settle();
    chk_status("R12 enable visible next cycle");
    do_cmd(8'h40); do_cmd(8'h60); do_cmd(8'h70);
    chk_status("R4 misc no-op codes");

    // R6/R5 fill, R6 blocked when full, R7 break overwrite
    for (int i = 0; i < 5; i++) do_rx(8'hA0 + 8'(i), 0);
    chk_status("R5 full flags");
    do_rx(8'h00, 1);
    chk_isr_irq();
    do_pop("R5 order a0");
    do_pop("R5 order a1");
    do_pop("R5 order a2");
    do_pop("R7 overwritten newest is zero");
    do_pop("R5 empty after drain");
    do_cmd(8'h50);
    bus_read(6'h14, q); chk("R7 break clear", q, exp_isr());

    // R9 select full mode, R10 mask
    bus_write(6'h00, 8'h40); if (m_ptr) m_mode1 = 8'h40; else m_mode0 = 8'h40; m_ptr = 1;
    do_cmd(8'h10); bus_write(6'h00, 8'h40); m_mode0 = 8'h40; m_ptr = 1;
    bus_write(6'h14, 8'h02); m_mask = 8'h02;
    do_rx(8'h31, 0);
    chk_isr_irq();
    for (int i = 0; i < 3; i++) do_rx(8'h32 + 8'(i), 0);
    chk_isr_irq();

    // R4 reset receiver
    do_cmd(8'h20);
    chk_status("R4 reset receiver");

    // R8 hold while not ready, then leave
    tx_ready = 0;
    bus_write(6'h0C, 8'hA5); m_tb = 8'hA5; m_txemp = 0;
    idle(2);
    chk("R8 held valid", {7'b0, tx_valid}, 8'h01);
    chk("R8 held data", tx_data, 8'hA5);
    tx_ready = 1;
    @(posedge clk); @(negedge clk); m_txemp = 1;
    chk_status("R8 sent");
    do_cmd(8'h08);
    bus_write(6'h0C, 8'h5A); m_tb = 8'h5A; m_txemp = 0;
    chk_status("R8 held while disabled");
    do_cmd(8'h30);
    chk_status("R4 reset transmitter");

    // Random phase
    seed = $urandom(32'h1234);
    for (int it = 0; it < 600; it++) begin
      int op;
      logic [7:0] r;
      op = $urandom_range(0, 9);
      r  = 8'($urandom);
      case (op)
        0, 1: do_rx(r, 0);
        2:    do_rx(8'h00, ($urandom_range(0, 3) == 0));
        3:    do_pop("R5 random pop");
        4:    begin
                r[3:2] = ($urandom_range(0, 2) == 0) ? 2'd1 : r[3:2];
                r[1:0] = ($urandom_range(0, 2) == 0) ? 2'd1 : r[1:0];
                do_cmd(r); tx_settle();
              end
        5:    begin bus_write(6'h0C, r); m_tb = r; m_txemp = 0; tx_settle(); end
        6:    chk_status("R3 random status");
        7:    chk_isr_irq();
        8:    begin bus_write(6'h14, r); m_mask = r; end
        default: begin
                if ($urandom_range(0, 1) == 0) begin
                  bus_write(6'h00, r);
                  if (m_ptr) m_mode1 = r; else m_mode0 = r;
                  m_ptr = 1;
                end else begin
                  bus_read(6'h00, q); chk("R2 random mode", q, m_ptr ? m_mode1 : m_mode0);
                end
              end
      endcase
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule